// File: doc/BRIEF.md
# Byte-Framed SPI Register Access Slave

This block is an SPI slave that lets an external master read and write an 8-bit register file inside the chip. The bus runs in mode 3: SCLK idles high, the master changes SDI on falling edges and samples SDO on rising edges, and bits are sent most significant first. A transfer starts when chip select falls. It consists of a control byte, an address byte and a data byte. The control byte sets the direction, selects register space or RAM space, and carries a two-bit channel number. The register file itself sits outside the block. The block reaches it through a synchronous port in the system clock domain.

Some masters can only move 16-bit words. For these masters, chip select may stay low for eight more clocks after the data byte, which gives a four-byte transfer. On a write, the block ignores the bits of this fourth byte. On a read, it shifts the same data byte out a second time, so the master can capture it in the second half of its word. The block oversamples chip select, SCLK and SDI into the system clock through a two-flop synchronizer and then detects edges. Because of this, SCLK must be much slower than the system clock.

Top module: `spi_ra_top`

## Requirements
- R1: While reset is asserted and after it is released with chip select high, `rf_we`, `rf_re` and `sdo_en` are all 0.
- R2: In a register write, the control byte has bit 7 = 0 and bit 6 = 0. The block raises `rf_we` for exactly one system cycle. At that time `rf_addr` equals the second byte, `rf_wdata` equals the third byte and `rf_chan` equals control bits 1:0.
- R3: The write strobe of R2 comes only after the 24th rising SCLK edge. If chip select rises before that edge, no write is issued.
- R4: In a register read, control bit 7 = 1 and bit 6 = 0. The block raises `rf_re` for one cycle, carrying the address byte, after the 16th rising SCLK edge and before the 17th falling edge. It reads `rf_rdata` in the following cycle.
- R5: `sdo_en` is 0 while chip select is high, during the control and address bytes, and throughout any write.
- R6: In a register read, the block drives the read value on `sdo` during the third byte, MSB first, with `sdo_en` = 1. Each bit changes after a falling SCLK edge, so it is stable at the next rising edge.
- R7: In a four-byte read, the fourth byte on `sdo` repeats the third byte bit for bit.
- R8: In a four-byte write, the fourth byte is ignored. Only one write strobe is issued, and it carries the third byte.
- R9: A transfer with control bit 6 = 1 selects RAM space. It raises neither `rf_we` nor `rf_re`, and `sdo_en` stays 0.
- R10: `rf_we` and `rf_re` are never high together, and each is high for at most one cycle per transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cs_n | input | 1 | SPI chip select, active low |
| sclk | input | 1 | SPI clock, idles high (mode 3) |
| sdi | input | 1 | Serial data from master |
| sdo | output | 1 | Serial data to master, valid when `sdo_en` is 1 |
| sdo_en | output | 1 | Output enable for the SDO pad driver; 0 means high impedance |
| rf_addr | output | 8 | Register file address |
| rf_chan | output | 2 | Channel select taken from the control byte |
| rf_wdata | output | 8 | Register file write data |
| rf_we | output | 1 | Register file write strobe, one cycle |
| rf_re | output | 1 | Register file read strobe, one cycle |
| rf_rdata | input | 8 | Register file read data, valid one cycle after `rf_re` |

## Verification
The assertions assume four things about the inputs. Each SCLK half period lasts many system cycles. SDI changes only while SCLK is low. Chip select moves only while SCLK is high. The register file returns read data exactly one cycle after `rf_re`. The bench meets these assumptions by driving every SCLK phase for ten system cycles and changing SDI right at each falling edge. It toggles chip select only with SCLK idle high, waits several cycles between transfers, and uses a register file model with a fixed one-cycle read latency. Random control bytes, addresses, lengths and early aborts vary only the contents of the frame, never its timing.

// File: rtl/spi_ra_pkg.sv
package spi_ra_pkg;
  localparam int BYTE_W    = 8;
  localparam int FRAME_MAX = 4 * BYTE_W;
  localparam int CNT_W     = $clog2(FRAME_MAX + 1);
  localparam int CHAN_W    = 2;

  localparam logic [CNT_W-1:0] CTRL_LAST = CNT_W'(BYTE_W - 1);
  localparam logic [CNT_W-1:0] ADDR_LAST = CNT_W'(2 * BYTE_W - 1);
  localparam logic [CNT_W-1:0] DATA_LAST = CNT_W'(3 * BYTE_W - 1);
  localparam logic [CNT_W-1:0] DATA_FIRST = CNT_W'(2 * BYTE_W);
  localparam logic [CNT_W-1:0] CNT_SAT   = CNT_W'(FRAME_MAX);

  typedef struct packed {
    logic              rd;
    logic              ram;
    logic [CHAN_W-1:0] chan;
  } ctrl_t;
endpackage

// File: rtl/spi_ra_sync.sv
module spi_ra_sync #(
  parameter int            W       = 1,
  parameter int            STAGES  = 2,
  parameter logic [W-1:0]  RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] pipe_q;
  logic [STAGES-1:0][W-1:0] pipe_d;

  always_comb begin
    pipe_d = {pipe_q[STAGES-2:0], d};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= {STAGES{RST_VAL}};
    else        pipe_q <= pipe_d;
  end

  assign q = pipe_q[STAGES-1];
endmodule

// File: rtl/spi_ra_frame.sv
module spi_ra_frame
  import spi_ra_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_act,
  input  logic              rise,
  input  logic              sdi_s,
  output logic [CNT_W-1:0]  bit_cnt,
  output ctrl_t             ctrl,
  output logic              ctrl_vld,
  output logic [BYTE_W-1:0] addr,
  output logic [BYTE_W-1:0] wdata,
  output logic              ev_addr,
  output logic              ev_data
);
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [BYTE_W-2:0] sh_q, sh_d;
  ctrl_t             ctrl_q, ctrl_d;
  logic              vld_q, vld_d;
  logic [BYTE_W-1:0] addr_q, addr_d, wdata_q, wdata_d;
  logic              eva_q, eva_d, evd_q, evd_d;

  always_comb begin
    cnt_d   = cnt_q;
    sh_d    = sh_q;
    ctrl_d  = ctrl_q;
    vld_d   = vld_q;
    addr_d  = addr_q;
    wdata_d = wdata_q;
    eva_d   = 1'b0;
    evd_d   = 1'b0;
    if (!cs_act) begin
      cnt_d = '0;
      vld_d = 1'b0;
    end else if (rise && (cnt_q != CNT_SAT)) begin
      cnt_d = cnt_q + 1'b1;
      sh_d  = {sh_q[BYTE_W-3:0], sdi_s};
      if (cnt_q == CTRL_LAST) begin
        ctrl_d.rd   = sh_q[BYTE_W-2];
        ctrl_d.ram  = sh_q[BYTE_W-3];
        ctrl_d.chan = {sh_q[0], sdi_s};
        vld_d       = 1'b1;
      end
      if (cnt_q == ADDR_LAST) begin
        addr_d = {sh_q, sdi_s};
        eva_d  = 1'b1;
      end
      if (cnt_q == DATA_LAST) begin
        wdata_d = {sh_q, sdi_s};
        evd_d   = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      sh_q    <= '0;
      ctrl_q  <= '0;
      vld_q   <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      eva_q   <= 1'b0;
      evd_q   <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      sh_q    <= sh_d;
      ctrl_q  <= ctrl_d;
      vld_q   <= vld_d;
      addr_q  <= addr_d;
      wdata_q <= wdata_d;
      eva_q   <= eva_d;
      evd_q   <= evd_d;
    end
  end

  assign bit_cnt  = cnt_q;
  assign ctrl     = ctrl_q;
  assign ctrl_vld = vld_q;
  assign addr     = addr_q;
  assign wdata    = wdata_q;
  assign ev_addr  = eva_q;
  assign ev_data  = evd_q;
endmodule

// File: rtl/spi_ra_access.sv
module spi_ra_access
  import spi_ra_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  ctrl_t             ctrl,
  input  logic              ctrl_vld,
  input  logic              ev_addr,
  input  logic              ev_data,
  input  logic [BYTE_W-1:0] rf_rdata,
  output logic              rf_we,
  output logic              rf_re,
  output logic              load,
  output logic              tx_en
);
  logic reg_rd, reg_wr;
  logic pend_q, pend_d;

  always_comb begin
    reg_rd = ctrl_vld && ctrl.rd && !ctrl.ram;
    reg_wr = ctrl_vld && !ctrl.rd && !ctrl.ram;
    rf_re  = ev_addr && reg_rd;
    rf_we  = ev_data && reg_wr;
    pend_d = rf_re;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= pend_d;
  end

  assign load  = pend_q;
  assign tx_en = reg_rd;

  logic unused_rdata;
  assign unused_rdata = ^rf_rdata;
endmodule

// File: rtl/spi_ra_tx.sv
module spi_ra_tx
  import spi_ra_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_act,
  input  logic              fall,
  input  logic              tx_en,
  input  logic [CNT_W-1:0]  bit_cnt,
  input  logic              load,
  input  logic [BYTE_W-1:0] load_data,
  output logic              sdo,
  output logic              sdo_en
);
  logic [BYTE_W-1:0] tx_q, tx_d;
  logic              sdo_q, sdo_d, oe_q, oe_d;

  always_comb begin
    tx_d  = tx_q;
    sdo_d = sdo_q;
    oe_d  = oe_q;
    if (!cs_act) begin
      oe_d  = 1'b0;
      sdo_d = 1'b0;
    end else begin
      if (load) begin
        tx_d = load_data;
      end else if (fall && tx_en && (bit_cnt >= DATA_FIRST)) begin
        sdo_d = tx_q[BYTE_W-1];
        tx_d  = {tx_q[BYTE_W-2:0], tx_q[BYTE_W-1]};
        oe_d  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q  <= '0;
      sdo_q <= 1'b0;
      oe_q  <= 1'b0;
    end else begin
      tx_q  <= tx_d;
      sdo_q <= sdo_d;
      oe_q  <= oe_d;
    end
  end

  assign sdo    = sdo_q;
  assign sdo_en = oe_q;
endmodule

// File: rtl/spi_ra_top.sv
module spi_ra_top
  import spi_ra_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic              sdi,
  output logic              sdo,
  output logic              sdo_en,
  output logic [BYTE_W-1:0] rf_addr,
  output logic [CHAN_W-1:0] rf_chan,
  output logic [BYTE_W-1:0] rf_wdata,
  output logic              rf_we,
  output logic              rf_re,
  input  logic [BYTE_W-1:0] rf_rdata
);
  logic [1:0] rst_pipe_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_core_n = rst_pipe_q[1];

  logic [2:0] pins_s;
  spi_ra_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b110)) u_sync (
    .clk(clk), .rst_n(rst_core_n), .d({cs_n, sclk, sdi}), .q(pins_s)
  );

  logic cs_act, sclk_s, sdi_s, sclk_prev_q, rise, fall;
  assign cs_act = !pins_s[2];
  assign sclk_s = pins_s[1];
  assign sdi_s  = pins_s[0];

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) sclk_prev_q <= 1'b1;
    else             sclk_prev_q <= sclk_s;
  end
  assign rise = sclk_s && !sclk_prev_q;
  assign fall = !sclk_s && sclk_prev_q;

  logic [CNT_W-1:0]  bit_cnt;
  ctrl_t             ctrl;
  logic              ctrl_vld, ev_addr, ev_data, load, tx_en, ctrl_ram;
  logic [BYTE_W-1:0] addr, wdata;

  spi_ra_frame u_frame (
    .clk(clk), .rst_n(rst_core_n), .cs_act(cs_act), .rise(rise), .sdi_s(sdi_s),
    .bit_cnt(bit_cnt), .ctrl(ctrl), .ctrl_vld(ctrl_vld), .addr(addr),
    .wdata(wdata), .ev_addr(ev_addr), .ev_data(ev_data)
  );

  spi_ra_access u_access (
    .clk(clk), .rst_n(rst_core_n), .ctrl(ctrl), .ctrl_vld(ctrl_vld),
    .ev_addr(ev_addr), .ev_data(ev_data), .rf_rdata(rf_rdata),
    .rf_we(rf_we), .rf_re(rf_re), .load(load), .tx_en(tx_en)
  );

  spi_ra_tx u_tx (
    .clk(clk), .rst_n(rst_core_n), .cs_act(cs_act), .fall(fall),
    .tx_en(tx_en), .bit_cnt(bit_cnt), .load(load), .load_data(rf_rdata),
    .sdo(sdo), .sdo_en(sdo_en)
  );

  assign ctrl_ram = ctrl.ram;
  assign rf_addr  = addr;
  assign rf_wdata = wdata;
  assign rf_chan  = ctrl.chan;
endmodule

// File: rtl/spi_ra_chk.sv
module spi_ra_chk
  import spi_ra_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             rf_we,
  input logic             rf_re,
  input logic             sdo_en,
  input logic [CNT_W-1:0] bit_cnt,
  input logic             ctrl_vld,
  input logic             ctrl_ram
);
  a_r10_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(rf_we && rf_re));
  a_r10_we_single: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |=> !rf_we);
  a_r10_re_single: assert property (@(posedge clk) disable iff (!rst_n)
    rf_re |=> !rf_re);
  a_r3_we_after_data_byte: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> (bit_cnt == CNT_W'(3 * BYTE_W)));
  a_r4_re_after_addr_byte: assert property (@(posedge clk) disable iff (!rst_n)
    rf_re |-> (bit_cnt == CNT_W'(2 * BYTE_W)));
  a_r5_drive_only_in_data: assert property (@(posedge clk) disable iff (!rst_n)
    sdo_en |-> (bit_cnt >= CNT_W'(2 * BYTE_W)));
  a_r9_ram_space_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_vld && ctrl_ram) |-> !(rf_we || rf_re || sdo_en));
endmodule

bind spi_ra_top spi_ra_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rf_we(rf_we), .rf_re(rf_re), .sdo_en(sdo_en),
  .bit_cnt(bit_cnt), .ctrl_vld(ctrl_vld), .ctrl_ram(ctrl_ram)
);

// File: tb/sim_spi_ra_top.sv
`timescale 1ns/1ps
module sim_spi_ra_top;
  localparam int HALF = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, sclk = 1'b1, sdi = 1'b0;
  logic sdo, sdo_en, rf_we, rf_re;
  logic [7:0] rf_addr, rf_wdata, rf_rdata;
  logic [1:0] rf_chan;

  always #2 clk = ~clk;

  spi_ra_top u0 (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
    .sdo(sdo), .sdo_en(sdo_en), .rf_addr(rf_addr), .rf_chan(rf_chan),
    .rf_wdata(rf_wdata), .rf_we(rf_we), .rf_re(rf_re), .rf_rdata(rf_rdata)
  );

  int errors = 0, checks = 0;
  bit done = 0;
  logic [7:0] mem [256];
  logic [7:0] model [256];
  int we_cnt = 0, re_cnt = 0, we_at = 0, re_at = 0, rise_cnt = 0;
  logic [7:0] we_addr, we_data, re_addr;
  logic [1:0] we_chan;
  logic [31:0] cap_sdo, cap_en;

  always @(posedge clk) begin
    if (rf_re) begin
      rf_rdata <= mem[rf_addr];
      re_cnt <= re_cnt + 1; re_at <= rise_cnt; re_addr <= rf_addr;
    end
    if (rf_we) begin
      mem[rf_addr] <= rf_wdata;
      we_cnt <= we_cnt + 1; we_at <= rise_cnt;
      we_addr <= rf_addr; we_data <= rf_wdata; we_chan <= rf_chan;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic [7:0] c, a, d, p, input int nbits);
    logic [31:0] fr;
    fr = {c, a, d, p};
    cap_sdo = '0; cap_en = '0; rise_cnt = 0;
    @(negedge clk); cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      sclk = 1'b0; sdi = fr[31-i];
      repeat (HALF) @(negedge clk);
      cap_sdo[i] = sdo; cap_en[i] = sdo_en;
      sclk = 1'b1; rise_cnt = i + 1;
      repeat (HALF) @(negedge clk);
    end
    cs_n = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  function automatic logic [7:0] cap_byte(input int base);
    logic [7:0] b;
    for (int k = 0; k < 8; k++) b[7-k] = cap_sdo[base+k];
    return b;
  endfunction

  task automatic run(input logic [7:0] c, a, d, input int nbits);
    int we0, re0;
    bit rd, ram, exp_we, exp_re;
    logic [7:0] exp_rd;
    we0 = we_cnt; re0 = re_cnt;
    rd = c[7]; ram = c[6];
    exp_rd = model[a];
    xfer(c, a, d, ~d ^ 8'h5a, nbits);
    exp_we = !rd && !ram && nbits >= 24;
    exp_re = rd && !ram && nbits >= 16;
    // R3 R8 R9: write count (aborts, fourth byte and RAM space give none extra)
    chk((we_cnt - we0) == int'(exp_we), "R3/R8/R9 write count", we_cnt - we0, int'(exp_we));
    chk((re_cnt - re0) == int'(exp_re), "R4/R9 read count", re_cnt - re0, int'(exp_re));
    chk(cap_en[15:0] == 16'h0, "R5 sdo_en during ctrl/addr", int'(cap_en[15:0]), 0);
    if (!exp_re || ram)
      chk(cap_en == 32'h0, "R5/R9 sdo_en without register read", int'(cap_en), 0);
    if (exp_we && (we_cnt - we0) == 1) begin
      chk(we_addr == a && we_data == d && we_chan == c[1:0], "R2 write fields",
          {we_chan, we_addr, we_data}, {c[1:0], a, d});
      chk(we_at == 24, "R3 write after 24th rise", we_at, 24);
      model[a] = d;
    end
    if (exp_re && (re_cnt - re0) == 1) begin
      chk(re_at == 16 && re_addr == a, "R4 read strobe timing/address",
          {re_at[7:0], re_addr}, {8'd16, a});
      if (nbits >= 24) begin
        chk(cap_byte(16) == exp_rd, "R6 read byte", cap_byte(16), exp_rd);
        chk(cap_en[23:16] == 8'hff, "R6 sdo_en in data byte", cap_en[23:16], 8'hff);
      end
      if (nbits == 32)
        chk(cap_byte(24) == exp_rd, "R7 repeated byte", cap_byte(24), exp_rd);
    end
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin
      mem[i] = 8'(i * 7 + 3);
      model[i] = 8'(i * 7 + 3);
    end
    rf_rdata = '0;
    repeat (5) @(negedge clk);
    chk(!rf_we && !rf_re && !sdo_en, "R1 in reset", {rf_we, rf_re, sdo_en}, 0);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    chk(!rf_we && !rf_re && !sdo_en, "R1 after reset", {rf_we, rf_re, sdo_en}, 0);

    run(8'h02, 8'h10, 8'hA5, 24);   // R2 plain write
    run(8'h80, 8'h10, 8'h00, 24);   // R6 read back
    run(8'h81, 8'h10, 8'h00, 32);   // R7 four-byte read
    run(8'h03, 8'h11, 8'h3C, 32);   // R8 four-byte write
    run(8'h80, 8'h11, 8'h00, 32);   // R8 readback
    run(8'h01, 8'h12, 8'hFF, 20);   // R3 abort in data byte
    run(8'h80, 8'h12, 8'h00, 24);   // R3 readback unchanged
    run(8'h40, 8'h13, 8'h77, 24);   // R9 RAM write
    run(8'hC0, 8'h13, 8'h00, 32);   // R9 RAM read
    run(8'h80, 8'h14, 8'h00, 12);   // R4 read aborted in address byte

    void'($urandom(32'h1234));
    for (int n = 0; n < 40; n++) begin
      logic [7:0] c;
      int nb, sel;
      c = 8'($urandom);
      c[6] = (($urandom % 4) == 0);
      sel = $urandom % 8;
      nb = (sel == 0) ? 8 + ($urandom % 16) : (sel < 4) ? 24 : 32;
      run(c, 8'($urandom % 16), 8'($urandom), nb);
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule